// File: doc/BRIEF.md
# Accumulator 8-bit Microcontroller Core

This core runs a small 12-bit instruction set around a single working register W. Each clock it fetches one word from an external program memory through a combinational address and data pair, decodes it and retires it. A 5-bit file address space holds three I/O ports (A at 0x05, B at 0x06, C at 0x07) and 24 general-purpose registers (0x08 to 0x1F). Every port pin has a direction bit: 1 makes it an input and 0 makes it an output. Only the dedicated direction instruction can write the direction bits.

Byte instructions carry a destination bit that sends the result either to W or back to the file register. The two bit-test instructions can cancel the instruction that follows them. Subroutine calls use a two-entry return stack, and the return instruction also loads a literal into W.

Top module: `acc8_core`

## Requirements
- R1: While reset is held and right after it, the program address is 0, W is 0, all port output latches are 0 and every direction bit is 1.
- R2: One instruction retires per clock and the program address advances by one, except for a taken jump, call or return.
- R3: Byte instructions are encoded as {2'b00, op[3:0], d, f[4:0]}, with op 0 MOVF, 1 MOVWF, 2 CLR, 3 INCF, 4 ADDWF, 5 ANDWF, 6 SWAPF and 7 TRIS; op 8 to 15 do nothing. With d=0 the result goes to W and f is unchanged. With d=1 the result goes to f and W is unchanged. MOVWF always writes f.
- R4: MOVF yields f, INCF yields f+1, ADDWF yields W+f, ANDWF yields W&f, and SWAPF yields f with its two nibbles exchanged; all results are modulo 256.
- R5: Control words are {2'b10, sel[1:0], k[7:0]}, with sel 0 GOTO k, 1 CALL k, 2 RETLW k and 3 MOVLW k. MOVLW loads k into W. CLR with d=1 is CLRF and zeroes f; CLR with d=0 is CLRW and zeroes W.
- R6: Bit tests are {2'b01, s, 1'b0, b[2:0], f[4:0]}. With s=0 (clear-test) the next instruction is cancelled when bit b of f is 0; with s=1 (set-test) it is cancelled when that bit is 1. A cancelled instruction changes nothing, including a jump. Words {2'b11, x} do nothing.
- R7: GOTO k makes k the next program address.
- R8: CALL k pushes the address after the CALL onto a two-entry stack and jumps to k. RETLW k pops that address into the program counter and loads k into W. Two nested calls return in the right order.
- R9: TRIS with f equal to 5, 6 or 7 copies W into the direction register of port A (low 4 bits), B or C. Writing those file addresses changes only the output latch, never the direction.
- R10: Reading a port returns, bit by bit, the pin input where the direction is 1 and the output latch where it is 0. Port A reads with its upper 4 bits as 0.
- R11: File addresses 0x00 to 0x04 read as 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rom_addr | output | 8 | Program memory address (the PC) |
| rom_data | input | 12 | Instruction word at rom_addr, same cycle |
| pa_in | input | 4 | Port A pin inputs |
| pa_out | output | 4 | Port A output latch |
| pa_dir | output | 4 | Port A direction, 1 = input |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output latch |
| pb_dir | output | 8 | Port B direction, 1 = input |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C output latch |
| pc_dir | output | 8 | Port C direction, 1 = input |

## Verification
A wrong cancel flag or a bad program counter shows on rom_addr in the very next cycle, and on the port latches once the test program writes its marker value. A corrupted W or file register stays hidden until the program copies it to port B or C, so each test program ends by storing every result it depends on to those ports. A wrong return-stack entry shows as a wrong marker written after the return. A direction register updated from the wrong path changes the pb_dir or pc_dir pins one cycle after the offending instruction.

// File: rtl/acc8_pkg.sv
package acc8_pkg;
  typedef enum logic [1:0] {
    CL_BYTE = 2'd0,
    CL_BIT  = 2'd1,
    CL_FLOW = 2'd2,
    CL_NOP  = 2'd3
  } ins_class_e;

  typedef enum logic [3:0] {
    OP_MOVF  = 4'd0,
    OP_MOVWF = 4'd1,
    OP_CLR   = 4'd2,
    OP_INCF  = 4'd3,
    OP_ADD   = 4'd4,
    OP_AND   = 4'd5,
    OP_SWAP  = 4'd6,
    OP_TRIS  = 4'd7
  } byte_op_e;

  typedef enum logic [1:0] {
    FL_GOTO  = 2'd0,
    FL_CALL  = 2'd1,
    FL_RETLW = 2'd2,
    FL_MOVLW = 2'd3
  } flow_op_e;

  localparam int unsigned PORTA_ADDR = 5;
  localparam int unsigned PORTB_ADDR = 6;
  localparam int unsigned PORTC_ADDR = 7;
  localparam int unsigned GPR_BASE   = 8;
endpackage

// File: rtl/acc8_alu.sv
module acc8_alu
  import acc8_pkg::*;
#(
  parameter int DW = 8
) (
  input  byte_op_e        op,
  input  logic [DW-1:0]   w_val,
  input  logic [DW-1:0]   f_val,
  output logic [DW-1:0]   res
);
  localparam int HALF = DW / 2;

  always_comb begin
    case (op)
      OP_MOVF:  res = f_val;
      OP_MOVWF: res = w_val;
      OP_CLR:   res = '0;
      OP_INCF:  res = f_val + DW'(1);
      OP_ADD:   res = w_val + f_val;
      OP_AND:   res = w_val & f_val;
      OP_SWAP:  res = {f_val[HALF-1:0], f_val[DW-1:HALF]};
      OP_TRIS:  res = w_val;
      default:  res = f_val;
    endcase
  end
endmodule

// File: rtl/acc8_stack.sv
module acc8_stack #(
  parameter int PW    = 8,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [PW-1:0] push_val,
  output logic [PW-1:0] top
);
  logic [PW-1:0] ent_q [DEPTH];
  logic [PW-1:0] ent_d [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ent_d[i] = ent_q[i];
      if (push) ent_d[i] = (i == 0) ? push_val : ent_q[(i > 0) ? i - 1 : 0];
      else if (pop) ent_d[i] = ent_q[(i + 1 < DEPTH) ? i + 1 : i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (push || pop) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
    end
  end

  assign top = ent_q[0];

  // R8: a pushed return address is the next one popped
  a_r8_push_top: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> top == $past(push_val));
endmodule

// File: rtl/acc8_files.sv
module acc8_files
  import acc8_pkg::*;
#(
  parameter int DW   = 8,
  parameter int AW   = 5,
  parameter int PA_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            we,
  input  logic            tris_we,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [PA_W-1:0] pa_in,
  output logic [PA_W-1:0] pa_out,
  output logic [PA_W-1:0] pa_dir,
  input  logic [DW-1:0]   pb_in,
  output logic [DW-1:0]   pb_out,
  output logic [DW-1:0]   pb_dir,
  input  logic [DW-1:0]   pc_in,
  output logic [DW-1:0]   pc_out,
  output logic [DW-1:0]   pc_dir
);
  localparam int NGPR = (1 << AW) - GPR_BASE;

  logic [DW-1:0] gpr [NGPR];
  logic [AW-1:0] gidx;
  logic          is_gpr, sel_a, sel_b, sel_c;

  assign gidx   = addr - AW'(GPR_BASE);
  assign is_gpr = (addr >= AW'(GPR_BASE));
  assign sel_a  = (addr == AW'(PORTA_ADDR));
  assign sel_b  = (addr == AW'(PORTB_ADDR));
  assign sel_c  = (addr == AW'(PORTC_ADDR));

  always_ff @(posedge clk) begin
    if (we && is_gpr) gpr[gidx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_out <= '0;
      pb_out <= '0;
      pc_out <= '0;
      pa_dir <= '1;
      pb_dir <= '1;
      pc_dir <= '1;
    end else begin
      if (we && sel_a)      pa_out <= wdata[PA_W-1:0];
      if (we && sel_b)      pb_out <= wdata;
      if (we && sel_c)      pc_out <= wdata;
      if (tris_we && sel_a) pa_dir <= wdata[PA_W-1:0];
      if (tris_we && sel_b) pb_dir <= wdata;
      if (tris_we && sel_c) pc_dir <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (is_gpr)     rdata = gpr[gidx];
    else if (sel_a) rdata = {{(DW-PA_W){1'b0}}, (pa_in & pa_dir) | (pa_out & ~pa_dir)};
    else if (sel_b) rdata = (pb_in & pb_dir) | (pb_out & ~pb_dir);
    else if (sel_c) rdata = (pc_in & pc_dir) | (pc_out & ~pc_dir);
  end

  // R9: direction bits move only on the direction instruction
  a_r9_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tris_we |=> $stable(pb_dir) && $stable(pc_dir) && $stable(pa_dir));
  a_r9_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
    tris_we && sel_c |=> pc_dir == $past(wdata));
endmodule

// File: rtl/acc8_core.sv
module acc8_core
  import acc8_pkg::*;
#(
  parameter int DW    = 8,
  parameter int PW    = 8,
  parameter int IW    = 12,
  parameter int AW    = 5,
  parameter int PA_W  = 4,
  parameter int DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PW-1:0]   rom_addr,
  input  logic [IW-1:0]   rom_data,
  input  logic [PA_W-1:0] pa_in,
  output logic [PA_W-1:0] pa_out,
  output logic [PA_W-1:0] pa_dir,
  input  logic [DW-1:0]   pb_in,
  output logic [DW-1:0]   pb_out,
  output logic [DW-1:0]   pb_dir,
  input  logic [DW-1:0]   pc_in,
  output logic [DW-1:0]   pc_out,
  output logic [DW-1:0]   pc_dir
);
  localparam int BW = $clog2(DW);

  logic rst_meta, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta} <= 2'b00;
    else        {rst_sync_n, rst_meta} <= {rst_meta, 1'b1};
  end

  logic [PW-1:0] pc_q, pc_d;
  logic [DW-1:0] w_q, w_d;
  logic          skip_q, skip_d;

  ins_class_e    cls;
  byte_op_e      bop;
  flow_op_e      fop;
  logic          dbit, bsel, live;
  logic [AW-1:0] faddr;
  logic [BW-1:0] bpos;
  logic [DW-1:0] lit;

  assign cls   = ins_class_e'(rom_data[IW-1:IW-2]);
  assign bop   = byte_op_e'(rom_data[IW-3:IW-6]);
  assign fop   = flow_op_e'(rom_data[IW-3:IW-4]);
  assign dbit  = rom_data[AW];
  assign faddr = rom_data[AW-1:0];
  assign bsel  = rom_data[IW-3];
  assign bpos  = rom_data[AW+BW-1:AW];
  assign lit   = rom_data[DW-1:0];
  assign live  = !skip_q;

  logic [DW-1:0] f_rd, alu_res;
  logic          f_we, tris_we, push, pop;
  logic [PW-1:0] ret_addr, pc_inc;

  assign pc_inc = pc_q + PW'(1);

  acc8_files #(.DW(DW), .AW(AW), .PA_W(PA_W)) u_files (
    .clk(clk), .rst_n(rst_sync_n), .addr(faddr), .we(f_we), .tris_we(tris_we),
    .wdata(alu_res), .rdata(f_rd),
    .pa_in(pa_in), .pa_out(pa_out), .pa_dir(pa_dir),
    .pb_in(pb_in), .pb_out(pb_out), .pb_dir(pb_dir),
    .pc_in(pc_in), .pc_out(pc_out), .pc_dir(pc_dir)
  );

  acc8_alu #(.DW(DW)) u_alu (
    .op(bop), .w_val(w_q), .f_val(f_rd), .res(alu_res)
  );

  acc8_stack #(.PW(PW), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_sync_n), .push(push), .pop(pop),
    .push_val(pc_inc), .top(ret_addr)
  );

  always_comb begin
    pc_d    = pc_inc;
    w_d     = w_q;
    skip_d  = 1'b0;
    f_we    = 1'b0;
    tris_we = 1'b0;
    push    = 1'b0;
    pop     = 1'b0;
    if (live) begin
      case (cls)
        CL_BYTE: begin
          if (bop == OP_TRIS) tris_we = 1'b1;
          else if (bop <= OP_SWAP) begin
            if (bop == OP_MOVWF || dbit) f_we = 1'b1;
            else                         w_d  = alu_res;
          end
        end
        CL_BIT:  skip_d = (f_rd[bpos] == bsel);
        CL_FLOW: begin
          case (fop)
            FL_GOTO:  pc_d = lit;
            FL_CALL:  begin pc_d = lit; push = 1'b1; end
            FL_RETLW: begin pc_d = ret_addr; pop = 1'b1; w_d = lit; end
            default:  w_d = lit;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q   <= '0;
      w_q    <= '0;
      skip_q <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      w_q    <= w_d;
      skip_q <= skip_d;
    end
  end

  assign rom_addr = pc_q;

  // R2: non-control instructions advance the address by one
  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cls != CL_FLOW) |=> pc_q == $past(pc_q) + PW'(1));
  // R6: a cancelled instruction leaves W alone and falls through
  a_r6_squash: assert property (@(posedge clk) disable iff (!rst_sync_n)
    skip_q |=> (w_q == $past(w_q)) && (pc_q == $past(pc_q) + PW'(1)) && !skip_q);
  // R7: a live GOTO lands on its literal
  a_r7_goto: assert property (@(posedge clk) disable iff (!rst_sync_n)
    live && cls == CL_FLOW && fop == FL_GOTO |=> pc_q == $past(lit));
  // R5: MOVLW loads its literal into W
  a_r5_movlw: assert property (@(posedge clk) disable iff (!rst_sync_n)
    live && cls == CL_FLOW && fop == FL_MOVLW |=> w_q == $past(lit));
endmodule

// File: tb/acc8_core_bench.sv
module acc8_core_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  rom_addr;
  logic [11:0] rom_data;
  logic [3:0]  pa_in, pa_out, pa_dir;
  logic [7:0]  pb_in, pb_out, pb_dir, pc_in, pc_out, pc_dir;
  logic [11:0] rom [256];

  int total = 0;
  int fails = 0;
  int wp = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rom_data = rom[rom_addr];

  acc8_core u_acc8_core (
    .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_data(rom_data),
    .pa_in(pa_in), .pa_out(pa_out), .pa_dir(pa_dir),
    .pb_in(pb_in), .pb_out(pb_out), .pb_dir(pb_dir),
    .pc_in(pc_in), .pc_out(pc_out), .pc_dir(pc_dir)
  );

  function automatic logic [11:0] e_byte(int op, int d, int f);
    return {2'b00, 4'(op), 1'(d), 5'(f)};
  endfunction
  function automatic logic [11:0] e_bit(int s, int b, int f);
    return {2'b01, 1'(s), 1'b0, 3'(b), 5'(f)};
  endfunction
  function automatic logic [11:0] e_flow(int sel, int k);
    return {2'b10, 2'(sel), 8'(k)};
  endfunction
  function automatic logic [7:0] alu_exp(int op, logic [7:0] w, logic [7:0] f);
    case (op)
      3: return f + 8'd1;
      4: return w + f;
      5: return w & f;
      6: return {f[3:0], f[7:4]};
      default: return f;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(logic [11:0] ins);
    rom[wp] = ins;
    wp++;
  endtask

  task automatic start_prog();
    for (int i = 0; i < 256; i++) rom[i] = 12'hC00;
    wp = 0;
    put(e_flow(3, 0));
    put(e_byte(7, 0, 6));
    put(e_byte(7, 0, 7));
  endtask

  task automatic end_run();
    put(e_flow(0, wp));
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (80) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_alu(int op, int d, logic [7:0] a, logic [7:0] b, int f);
    start_prog();
    put(e_flow(3, a)); put(e_byte(1, 0, f)); put(e_flow(3, b));
    put(e_byte(op, d, f));
    if (d == 1) begin
      put(e_byte(1, 0, 7)); put(e_byte(0, 0, f)); put(e_byte(1, 0, 6));
      end_run();
      check("R3 W kept when d=1", pc_out, b);
      check("R4 result in f", pb_out, alu_exp(op, b, a));
    end else begin
      put(e_byte(1, 0, 6)); put(e_byte(0, 0, f)); put(e_byte(1, 0, 7));
      end_run();
      check("R4 result in W", pb_out, alu_exp(op, b, a));
      check("R3 f kept when d=0", pc_out, a);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        fails++; total++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] a, b, v;
    int f, bp, s;
    void'($urandom(32'd2024));
    pa_in = 4'h0; pb_in = 8'h00; pc_in = 8'h00;
    for (int i = 0; i < 256; i++) rom[i] = 12'hC00;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 pc", rom_addr, 8'h00);
    check("R1 dir", {pa_dir, pb_dir, pc_dir}, 20'hFFFFF);
    check("R1 latches", {pa_out, pb_out, pc_out}, 20'h0);

    // R2 R5 R9: literal to port, TRIS sets direction
    for (int it = 0; it < 3; it++) begin
      a = 8'($urandom);
      start_prog();
      put(e_flow(3, a)); put(e_byte(1, 0, 6));
      end_run();
      check("R5 MOVLW to port B", pb_out, a);
      check("R9 TRIS dir B/C", {pb_dir, pc_dir}, 16'h0);
      check("R2 parked at self loop", rom_addr, 8'(wp - 1));
    end

    // R3 R4: random ALU operations, both destinations
    for (int it = 0; it < 12; it++) begin
      a = 8'($urandom); b = 8'($urandom);
      f = 8 + int'($urandom % 24);
      run_alu(3 + (it % 4), it / 4 % 2, a, b, f);
    end
    run_alu(3, 1, 8'hFF, 8'h12, 31);
    run_alu(4, 0, 8'hF0, 8'h20, 8);
    run_alu(0, 0, 8'h5C, 8'h01, 9);

    // R5: CLRF and CLRW
    a = 8'($urandom) | 8'h01;
    start_prog();
    put(e_flow(3, a)); put(e_byte(1, 0, 31)); put(e_byte(2, 1, 31));
    put(e_byte(1, 0, 7)); put(e_byte(0, 0, 31)); put(e_byte(1, 0, 6));
    end_run();
    check("R5 CLRF zeroes f", pb_out, 8'h00);
    check("R5 CLRF keeps W", pc_out, a);
    start_prog();
    put(e_flow(3, a)); put(e_byte(1, 0, 31)); put(e_byte(2, 0, 31));
    put(e_byte(1, 0, 6)); put(e_byte(0, 0, 31)); put(e_byte(1, 0, 7));
    end_run();
    check("R5 CLRW zeroes W", pb_out, 8'h00);
    check("R5 CLRW keeps f", pc_out, a);

    // R6: bit tests with random values
    for (int it = 0; it < 8; it++) begin
      v = 8'($urandom); bp = int'($urandom % 8); s = it % 2;
      start_prog();
      put(e_flow(3, v)); put(e_byte(1, 0, 8)); put(e_flow(3, 8'h11));
      put(e_bit(s, bp, 8)); put(e_flow(3, 8'h22)); put(e_byte(1, 0, 6));
      end_run();
      check("R6 skip decision", pb_out, (v[bp] == 1'(s)) ? 8'h11 : 8'h22);
    end
    // R6: a cancelled GOTO, then the set-test on a set bit
    start_prog();
    put(e_flow(3, 8'h80)); put(e_byte(1, 0, 20)); put(e_bit(1, 7, 20));
    put(e_flow(0, 200)); put(e_flow(3, 8'h3C)); put(e_byte(1, 0, 6));
    end_run();
    check("R6 cancelled GOTO", pb_out, 8'h3C);

    // R7: GOTO over a block
    start_prog();
    put(e_flow(0, 40)); put(e_flow(3, 8'hEE)); put(e_byte(1, 0, 6));
    wp = 40;
    put(e_flow(3, 8'h5A)); put(e_byte(1, 0, 6));
    end_run();
    check("R7 GOTO target", pb_out, 8'h5A);

    // R8: nested CALL/RETLW
    start_prog();
    put(e_flow(1, 20)); put(e_byte(1, 0, 6));
    rom[20] = e_flow(1, 30); rom[21] = e_byte(1, 0, 7); rom[22] = e_flow(2, 8'h33);
    rom[30] = e_flow(2, 8'h44);
    end_run();
    check("R8 outer return W", pb_out, 8'h33);
    check("R8 inner return W", pc_out, 8'h44);

    // R9 R10: mixed direction on port C, port A read
    pa_in = 4'($urandom); pc_in = 8'($urandom);
    start_prog();
    put(e_flow(3, 8'h0F)); put(e_byte(7, 0, 7));
    put(e_flow(3, 8'hA5)); put(e_byte(1, 0, 7));
    put(e_byte(0, 0, 5)); put(e_byte(1, 0, 6));
    end_run();
    check("R10 port A read", pb_out, {4'h0, pa_in});
    check("R9 MOVWF leaves dir", pc_dir, 8'h0F);
    check("R9 MOVWF writes latch", pc_out, 8'hA5);
    start_prog();
    put(e_flow(3, 8'h0F)); put(e_byte(7, 0, 7));
    put(e_flow(3, 8'hA5)); put(e_byte(1, 0, 7));
    put(e_byte(0, 0, 7)); put(e_byte(1, 0, 6));
    end_run();
    check("R10 port C mixed read", pb_out, {4'hA, pc_in[3:0]});

    // R11: low addresses read zero, writes ignored
    start_prog();
    put(e_flow(3, 8'h77)); put(e_byte(1, 0, 3)); put(e_flow(3, 8'h12));
    put(e_byte(0, 0, 3)); put(e_byte(1, 0, 6));
    end_run();
    check("R11 low address reads 0", pb_out, 8'h00);
    // R3: undefined byte op does nothing
    start_prog();
    put(e_flow(3, 8'h66)); put(e_byte(1, 0, 12)); put(e_byte(12, 0, 12));
    put(e_byte(12, 1, 12)); put(e_byte(1, 0, 6)); put(e_byte(0, 0, 12)); put(e_byte(1, 0, 7));
    end_run();
    check("R3 undefined op keeps W", pb_out, 8'h66);
    check("R3 undefined op keeps f", pc_out, 8'h66);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule